// File: doc/BRIEF.md
# Neighbor Word Substitution Scorer

This block scores short protein words for a seed search. Residue codes arrive one per handshake and enter a small shift register. The register always holds the most recent query word, with the oldest residue in word position 0. Once the register holds a full word, each accepted residue starts a sweep. During a sweep an iterator visits every candidate word that can be built from the residue alphabet, one candidate per clock. For each word position, a parallel lookup table returns the substitution score for the pair (query residue, candidate residue). The per-position scores are sign-extended and added. A comparator then checks the sum against a threshold input.

Every candidate whose sum reaches the threshold is offered downstream with a valid/ready handshake, together with its score. While an offer waits, the iterator pauses. The input side is held off for the whole sweep, and a one-cycle completion pulse marks the end of each sweep. The table contents are computed from a fixed scoring rule when the design is elaborated.

Top module: `nbr_word_scorer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and sweep_done is 0.
- R2: An accepted residue (in_valid and in_ready both high at a clock edge) shifts into the query word, which holds the last three accepted residues with the oldest in position 0. No sweep starts before the third residue since reset. The third residue and every later accepted residue each start a sweep over the word that now ends with that residue.
- R3: in_ready is 0 for the whole of a sweep. in_valid and in_res are ignored while in_ready is 0, and the query word does not change during a sweep.
- R4: A sweep visits all ALPHA^3 candidate words, with candidate codes 0..ALPHA-1 in each position. Position 2 changes fastest and position 0 slowest. out_word packs position 0 in bits 14:10, position 1 in bits 9:5 and position 2 in bits 4:0.
- R5: The table for each position is addressed by {query residue, candidate residue}, 5 bits each. Each entry is a 4-bit signed value. When q equals c the entry is 4 + (q mod 4). Otherwise it is ((3q + 5c) mod 9) - 4.
- R6: out_score is the sum of the three table entries, as a 7-bit two's-complement value.
- R7: out_valid is 1 during a sweep exactly for the candidates whose signed sum is greater than or equal to the signed 7-bit threshold. Candidates below the threshold pass in one cycle and produce no offer.
- R8: While out_valid is 1 and out_ready is 0, the iterator holds, and out_valid, out_word and out_score stay unchanged in the next cycle.
- R9: sweep_done is a single-cycle pulse in the cycle after the last candidate is consumed. in_ready returns to 1 in that same cycle. A sweep therefore lasts ALPHA^3 cycles plus one cycle for each stalled offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Residue code offered |
| in_ready | output | 1 | Block can take a residue (idle) |
| in_res | input | 5 | Residue code |
| threshold | input | 7 | Signed minimum score for an offer; hold stable during a sweep |
| out_valid | output | 1 | Qualifying candidate offered |
| out_ready | input | 1 | Downstream takes the offer |
| out_word | output | 15 | Candidate word, position 0 in the top bits |
| out_score | output | 7 | Signed score of the candidate |
| sweep_done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench builds the block with ALPHA = 5, so each sweep has 125 candidates and can be compared in order against a list the bench computes arithmetically from the scoring rule. With this small alphabet the bench can reach several boundaries within a short run:
- a threshold of -12, at which every candidate qualifies;
- a threshold of 22, at which none do;
- a threshold of 21, at which only the all-diagonal word with code 3 qualifies.

The bench also runs sweeps with periodic back-pressure and counts the exact sweep length. In one sweep it drives a junk residue that the block must ignore, and a later sweep shows that the query word was not disturbed.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  localparam int RES_W_DEF   = 5;
  localparam int SCORE_W_DEF = 4;

  // Substitution rule: diagonal rewards, off-diagonal spread over -4..4
  function automatic int subst_score(input int q, input int c);
    if (q == c) return 4 + (q % 4);
    return ((3 * q + 5 * c) % 9) - 4;
  endfunction

  // Lowest and highest sum reachable with a given entry width and word length
  function automatic int sum_floor(input int score_w, input int word_len);
    return -word_len * (1 << (score_w - 1));
  endfunction

  function automatic int sum_ceil(input int score_w, input int word_len);
    return word_len * ((1 << (score_w - 1)) - 1);
  endfunction

endpackage

// File: rtl/nbr_score_rom.sv
module nbr_score_rom #(
  parameter int RES_W   = nbr_pkg::RES_W_DEF,
  parameter int SCORE_W = nbr_pkg::SCORE_W_DEF
) (
  input  logic [RES_W-1:0]          q_res,
  input  logic [RES_W-1:0]          c_res,
  output logic signed [SCORE_W-1:0] score
);
  localparam int DEPTH = 1 << (2 * RES_W);
  localparam int MASK  = (1 << RES_W) - 1;

  logic signed [SCORE_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign rom[i] = SCORE_W'(nbr_pkg::subst_score(i >> RES_W, i & MASK));
  end

  assign score = rom[{q_res, c_res}];
endmodule

// File: rtl/nbr_query_shift.sv
module nbr_query_shift #(
  parameter int RES_W    = nbr_pkg::RES_W_DEF,
  parameter int WORD_LEN = 3,
  localparam int CNT_W   = $clog2(WORD_LEN + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [RES_W-1:0]          din,
  output logic [WORD_LEN*RES_W-1:0] word,
  output logic [CNT_W-1:0]          fill
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      fill <= '0;
    end else if (shift_en) begin
      word <= {word[(WORD_LEN-1)*RES_W-1:0], din};
      if (fill != CNT_W'(WORD_LEN)) fill <= fill + 1'b1;
    end
  end

  AST_FILL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(WORD_LEN)); // R2
  AST_SHIFT_ENTERS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> word[RES_W-1:0] == $past(din)); // R2
endmodule

// File: rtl/nbr_iterator.sv
module nbr_iterator #(
  parameter int RES_W    = nbr_pkg::RES_W_DEF,
  parameter int WORD_LEN = 3,
  parameter int ALPHA    = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      step,
  output logic [WORD_LEN*RES_W-1:0] cand,
  output logic                      busy,
  output logic                      last,
  output logic                      done
);
  localparam logic [RES_W-1:0] MAXD = RES_W'(ALPHA - 1);

  logic [RES_W-1:0]    dig [WORD_LEN];
  logic [WORD_LEN-1:0] at_max;
  logic [WORD_LEN-1:0] inc;

  always_comb begin
    logic cy;
    cy = step;
    for (int p = WORD_LEN - 1; p >= 0; p--) begin
      inc[p] = cy;
      cy     = cy & at_max[p];
    end
  end

  for (genvar p = 0; p < WORD_LEN; p++) begin : g_digit
    assign at_max[p] = (dig[p] == MAXD);
    assign cand[(WORD_LEN-1-p)*RES_W +: RES_W] = dig[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dig[p] <= '0;
      else if (start)  dig[p] <= '0;
      else if (inc[p]) dig[p] <= at_max[p] ? '0 : dig[p] + 1'b1;
    end

    AST_DIGIT_IN_ALPHABET: assert property (@(posedge clk) disable iff (!rst_n)
      dig[p] <= MAXD); // R4
  end

  assign last = &at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= busy & step & last;
      if (start)              busy <= 1'b1;
      else if (step && last)  busy <= 1'b0;
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last && step)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/nbr_word_scorer.sv
module nbr_word_scorer #(
  parameter int RES_W    = nbr_pkg::RES_W_DEF,
  parameter int SCORE_W  = nbr_pkg::SCORE_W_DEF,
  parameter int WORD_LEN = 3,
  parameter int ALPHA    = 20,
  localparam int SUM_W   = SCORE_W + 3,
  localparam int WORD_W  = WORD_LEN * RES_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [RES_W-1:0]        in_res,
  input  logic signed [SUM_W-1:0] threshold,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_word,
  output logic signed [SUM_W-1:0] out_score,
  output logic                    sweep_done
);
  localparam int CNT_W = $clog2(WORD_LEN + 1);
  localparam logic signed [SUM_W-1:0] SUM_LO = SUM_W'(nbr_pkg::sum_floor(SCORE_W, WORD_LEN));
  localparam logic signed [SUM_W-1:0] SUM_HI = SUM_W'(nbr_pkg::sum_ceil(SCORE_W, WORD_LEN));

  logic                      accept, start, busy, last, step, hit;
  logic [WORD_W-1:0]         query_word, cand_word;
  logic [CNT_W-1:0]          fill;
  logic signed [SCORE_W-1:0] scores [WORD_LEN];
  logic signed [SUM_W-1:0]   sum;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;
  assign start    = accept & (fill >= CNT_W'(WORD_LEN - 1));

  nbr_query_shift #(.RES_W(RES_W), .WORD_LEN(WORD_LEN)) shift_i (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(in_res),
    .word(query_word), .fill(fill)
  );

  nbr_iterator #(.RES_W(RES_W), .WORD_LEN(WORD_LEN), .ALPHA(ALPHA)) iter_i (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .cand(cand_word), .busy(busy), .last(last), .done(sweep_done)
  );

  for (genvar p = 0; p < WORD_LEN; p++) begin : g_table
    nbr_score_rom #(.RES_W(RES_W), .SCORE_W(SCORE_W)) rom_i (
      .q_res(query_word[(WORD_LEN-1-p)*RES_W +: RES_W]),
      .c_res(cand_word[(WORD_LEN-1-p)*RES_W +: RES_W]),
      .score(scores[p])
    );
  end

  always_comb begin
    sum = '0;
    for (int p = 0; p < WORD_LEN; p++)
      sum = sum + {{(SUM_W-SCORE_W){scores[p][SCORE_W-1]}}, scores[p]};
  end

  assign hit       = (sum >= threshold);
  assign out_valid = busy & hit;
  assign out_word  = cand_word;
  assign out_score = sum;
  assign step      = busy & (~hit | out_ready);

  AST_NO_RESTART_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R3
  AST_QUERY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(query_word)); // R3
  AST_SUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (out_score >= SUM_LO && out_score <= SUM_HI)); // R6
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_score))); // R8
  AST_OFFER_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R7
endmodule

// File: tb/nbr_word_scorer_tb.sv
module nbr_word_scorer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ALPHA      = 5;
  localparam int NCOMB      = ALPHA * ALPHA * ALPHA;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [4:0]        in_res = '0;
  logic signed [6:0] threshold = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [14:0]       out_word;
  logic signed [6:0] out_score;
  logic              sweep_done;

  int checks = 0;
  int errors = 0;
  int exp_word [NCOMB];
  int exp_score [NCOMB];
  int n_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_word_scorer #(.ALPHA(ALPHA)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_res(in_res), .threshold(threshold), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .out_score(out_score),
    .sweep_done(sweep_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // R5 rule restated: same-code pairs score 4..7 by low two bits
  function automatic int ref_entry(input int q, input int c);
    if (q == c) return 4 + (q & 3);
    return ((3 * q + 5 * c) % 9) - 4;
  endfunction

  // Expected offers, in R4 order (position 2 fastest)
  task automatic build_expected(input int q0, input int q1, input int q2, input int thr);
    int s;
    n_exp = 0;
    for (int a = 0; a < ALPHA; a++)
      for (int b = 0; b < ALPHA; b++)
        for (int c = 0; c < ALPHA; c++) begin
          s = ref_entry(q0, a) + ref_entry(q1, b) + ref_entry(q2, c);
          if (s >= thr) begin
            exp_word[n_exp]  = (a << 10) | (b << 5) | c;
            exp_score[n_exp] = s;
            n_exp++;
          end
        end
  endtask

  task automatic send(input int r);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    in_valid = 1'b1;
    in_res   = 5'(r);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_sweep(input int stall_mod, input bit junk);
    int  idx = 0;
    int  stalls = 0;
    int  cyc = 0;
    bit  held = 0;
    int  held_word = 0;
    bit  rdy;
    forever begin
      @(negedge clk);
      cyc++;
      if (junk && cyc == 1) begin in_valid = 1'b1; in_res = 5'd31; end
      if (junk && cyc == 10) begin
        chk(in_ready == 1'b0, "R3 in_ready low in sweep", int'(in_ready), 0);
        in_valid = 1'b0;
      end
      if (sweep_done) break;
      if (cyc > NCOMB + 400) begin
        chk(1'b0, "R9 sweep never ended", cyc, NCOMB + 1);
        break;
      end
      if (held) chk(out_valid && int'(out_word) == held_word,
                    "R8 offer held under stall", int'(out_word), held_word);
      held = 0;
      if (out_valid) begin
        if (idx < n_exp) begin
          chk(int'(out_word) == exp_word[idx], "R4 R7 offered word", int'(out_word), exp_word[idx]);
          chk(int'(out_score) == exp_score[idx], "R5 R6 offered score", int'(out_score), exp_score[idx]);
        end else chk(1'b0, "R7 extra offer", int'(out_word), -1);
        rdy = !(stall_mod > 0 && (cyc % stall_mod) == 0);
        out_ready = rdy;
        if (rdy) idx++;
        else begin stalls++; held = 1; held_word = int'(out_word); end
      end else out_ready = 1'b1;
    end
    out_ready = 1'b0;
    chk(idx == n_exp, "R7 number of offers", idx, n_exp);
    chk(cyc == NCOMB + stalls + 1, "R9 sweep length", cyc, NCOMB + stalls + 1);
    chk(in_ready == 1'b1, "R9 in_ready with done", int'(in_ready), 1);
    @(negedge clk);
    chk(sweep_done == 1'b0, "R9 done single cycle", int'(sweep_done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(sweep_done == 1'b0, "R1 reset sweep_done", int'(sweep_done), 0);
    rst_n = 1'b1;

    // R2: two residues do not start a sweep
    send(1);
    send(2);
    repeat (3) begin
      @(negedge clk);
      chk(in_ready == 1'b1 && out_valid == 1'b0, "R2 no sweep before full word",
          int'(in_ready), 1);
    end

    // Lowest threshold: every candidate qualifies
    threshold = -7'sd12;
    build_expected(1, 2, 3, -12);
    send(3);
    run_sweep(0, 1'b0);

    // R2 sliding window {2,3,4}, with back-pressure (R8)
    threshold = 7'sd5;
    build_expected(2, 3, 4, 5);
    send(4);
    run_sweep(3, 1'b0);

    // R3: junk residue during the sweep must be ignored
    threshold = 7'sd0;
    build_expected(3, 4, 0, 0);
    send(0);
    run_sweep(2, 1'b1);

    // Word {4,0,3} confirms the junk residue never entered
    threshold = 7'sd2;
    build_expected(4, 0, 3, 2);
    send(3);
    run_sweep(0, 1'b0);

    // Threshold above the maximum: no offers
    threshold = 7'sd22;
    build_expected(0, 3, 3, 22);
    send(3);
    run_sweep(0, 1'b0);

    // Threshold at the maximum: only {3,3,3} with score 21
    threshold = 7'sd21;
    build_expected(3, 3, 3, 21);
    chk(n_exp == 1, "R5 bench expects single top hit", n_exp, 1);
    send(3);
    run_sweep(4, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule